// File: doc/BRIEF.md
# Descriptor Ring Progress and Status Tracker

This block follows one audio-style DMA channel as it walks a ring of buffer descriptors. The datapath reports three kinds of events: a buffer has finished (along with that descriptor's interrupt-on-completion flag), a descriptor has been fetched, and a sample transfer has reached a FIFO limit. The control register supplies a run bit. From these the block keeps a current index, a last valid index and a 16-bit status word. The status word holds write-one-to-clear event flags and read-only state flags. The block also drives a single interrupt line.

A parameter chooses receive or transmit behaviour. The two variants differ in when the last-buffer event fires. In receive mode the FIFO limit means "full", so the blocked sample is dropped. In transmit mode the limit means "empty", so the last good sample goes out again. The engine stops by itself once the buffer at the last valid index is done. Writing a new last valid index lets it carry on.

The register port has four word-sized registers, picked by a 2-bit select:
- 0: status.
- 1: control. Bit 0 is run, bit 1 enables the interrupt for the last-buffer event, bit 2 enables the interrupt for FIFO errors.
- 2: last valid index, in bits 4:0.
- 3: current index, read-only.

Top module: `dma_ring_status`

## Requirements
- R1: After reset the status register reads 0x0001, the current index, last valid index and control register read 0, and the interrupt is low.
- R2: Status bits 15:5 always read 0. Only full-word accesses (acc_word=1) take effect. A write with acc_word=0 changes no register, and a read with acc_word=0 returns 0.
- R3: While running, each finished buffer moves the current index on by one, wrapping from 31 to 0, unless it already equals the last valid index. In that case status bit 1 becomes 1, and further finished buffers are ignored until a new last valid index is written.
- R4: Status bit 3 becomes 1 on a finished buffer whose completion flag is set, but only while running.
- R5: Status bit 2 marks the last-buffer event. In receive mode it becomes 1 when the buffer at the last valid index finishes. In transmit mode it becomes 1 when a descriptor is fetched while the current index equals the last valid index. Both cases apply only while running.
- R6: Status bit 4 becomes 1 when a transfer request meets the FIFO limit while running. It never becomes 1 while bit 0 is 1.
- R7: fifo_move equals xfer_req AND NOT fifo_lim, and fifo_stall equals xfer_req AND fifo_lim, in the same cycle. In receive mode a stall drops the sample; in transmit mode it repeats the last sample.
- R8: A word write to register 0 with ones in bits 4:2 clears those status bits at the next edge. Bits 1 and 0 are unaffected. If a set event arrives in the same cycle, the set wins.
- R9: A word write to register 2 loads the last valid index and clears status bit 1. If bit 1 was 1 and the new value differs from the current index, the current index moves on by one.
- R10: Status bit 0 (halted) reads 1 whenever the run bit is 0 or status bit 1 is 1.
- R11: irq is status bit 3, OR status bit 2 AND control bit 1, OR status bit 4 AND control bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_sel | input | 2 | Register select |
| acc_wr | input | 1 | Write strobe |
| acc_word | input | 1 | Access is a full 16-bit word |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data (combinational) |
| buf_done | input | 1 | Last sample of the current buffer processed |
| buf_ioc | input | 1 | Completion flag of the finished buffer's descriptor |
| desc_fetch | input | 1 | Descriptor at the current index fetched |
| xfer_req | input | 1 | Sample push (receive) or pop (transmit) request |
| fifo_lim | input | 1 | FIFO full (receive) or empty (transmit) |
| fifo_move | output | 1 | FIFO pointer may advance |
| fifo_stall | output | 1 | Sample dropped (receive) or repeated (transmit) |
| irq | output | 1 | Interrupt request |

## Verification
A wrong current index or completion flag shows up in the readable index register and in status bit 1 at the edge after the buffer event that caused it. If the block fails to halt, later finished buffers keep moving the index, and this is visible on the very next cycle. Flag priority errors show up as a status bit that is cleared when it should be set, or the reverse, in the cycle after a write that coincides with an event. Interrupt masking mistakes show on irq in that same cycle. The bench runs a receive instance and a transmit instance side by side on the same stimulus, so a direction mix-up shows up as the two disagreeing over the last-buffer event.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int STAT_W = 16;
    localparam int NFLAG  = 3;

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_LVI  = 2'd2,
        SEL_CIV  = 2'd3
    } sel_e;

    // control register, bit 0 is run
    typedef struct packed {
        logic fe_ie;
        logic lvb_ie;
        logic run;
    } ctrl_t;

    // event flags, ordered as status bits 4:2
    typedef struct packed {
        logic fifo;
        logic buf_c;
        logic lvb;
    } flags_t;

    function automatic logic [STAT_W-1:0] pack_stat(flags_t f, logic celv, logic halt);
        return {{(STAT_W-5){1'b0}}, f, celv, halt};
    endfunction

endpackage

// File: rtl/rs_ctrl_regs.sv
module rs_ctrl_regs
    import rs_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  sel_e             sel,
    input  logic             wr,
    input  logic             word,
    input  logic [STAT_W-1:0] wdata,
    output ctrl_t            ctrl_q,
    output logic [IDX_W-1:0] lvi_q,
    output logic             lvi_wr,
    output flags_t           clr
);

    logic wr_ok;
    logic ctrl_wr;

    assign wr_ok   = wr && word;
    assign ctrl_wr = wr_ok && (sel == SEL_CTRL);
    assign lvi_wr  = wr_ok && (sel == SEL_LVI);

    always_comb begin
        clr = '0;
        if (wr_ok && (sel == SEL_STAT)) begin
            clr = flags_t'(wdata[4:2]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            lvi_q  <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= ctrl_t'(wdata[2:0]);
            end
            if (lvi_wr) begin
                lvi_q <= wdata[IDX_W-1:0];
            end
        end
    end

    AST_BYTE_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr && !word) |=> ($stable(ctrl_q) && $stable(lvi_q)));  // R2

endmodule

// File: rtl/rs_ring_track.sv
module rs_ring_track #(
    parameter int IDX_W  = 5,
    parameter bit TX_DIR = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             buf_done,
    input  logic             desc_fetch,
    input  logic             lvi_wr,
    input  logic [IDX_W-1:0] lvi_q,
    input  logic [IDX_W-1:0] lvi_new,
    output logic [IDX_W-1:0] civ_q,
    output logic             celv_q,
    output logic             halted,
    output logic             running,
    output logic             ev_last
);

    logic at_last;
    logic fin;
    logic step;
    logic fetch_last;

    assign halted     = !run || celv_q;
    assign running    = !halted;
    assign at_last    = (civ_q == lvi_q);
    assign fin        = buf_done && running && at_last;
    assign step       = buf_done && running && !at_last;
    assign fetch_last = desc_fetch && running && at_last;

    // transmit signals the last buffer on fetch, receive on completion
    assign ev_last = TX_DIR ? fetch_last : fin;

    always_ff @(posedge clk) begin
        if (rst) begin
            civ_q  <= '0;
            celv_q <= 1'b0;
        end else begin
            if (lvi_wr) begin
                celv_q <= 1'b0;
                if (celv_q && (lvi_new != civ_q)) begin
                    civ_q <= civ_q + 1'b1;
                end
            end else if (fin) begin
                celv_q <= 1'b1;
            end
            if (step) begin
                civ_q <= civ_q + 1'b1;
            end
        end
    end

    AST_CIV_STEP: assert property (@(posedge clk) disable iff (rst)
        (civ_q != $past(civ_q)) |-> (civ_q == $past(civ_q) + 1'b1));  // R3

    AST_CELV_AT_LAST: assert property (@(posedge clk) disable iff (rst)
        celv_q |-> (civ_q == lvi_q));  // R3

    AST_HALT_HOLDS_CIV: assert property (@(posedge clk) disable iff (rst)
        (halted && !lvi_wr) |=> $stable(civ_q));  // R3

endmodule

// File: rtl/rs_evt_flags.sv
module rs_evt_flags
    import rs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t set_i,
    input  flags_t clr_i,
    input  ctrl_t  ctrl,
    output flags_t flags_q,
    output logic   irq
);

    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;
    logic [NFLAG-1:0] q_v;

    assign set_v   = set_i;
    assign clr_v   = clr_i;
    assign flags_q = flags_t'(q_v);

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                q_v[i] <= 1'b0;
            end else begin
                q_v[i] <= set_v[i] || (q_v[i] && !clr_v[i]);
            end
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set_v[i] |=> q_v[i]);  // R8

        AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
            (clr_v[i] && !set_v[i]) |=> !q_v[i]);  // R8
    end

    assign irq = flags_q.buf_c
               || (flags_q.lvb  && ctrl.lvb_ie)
               || (flags_q.fifo && ctrl.fe_ie);

endmodule

// File: rtl/dma_ring_status.sv
module dma_ring_status
    import rs_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter bit TX_DIR = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  acc_sel,
    input  logic        acc_wr,
    input  logic        acc_word,
    input  logic [15:0] acc_wdata,
    output logic [15:0] acc_rdata,
    input  logic        buf_done,
    input  logic        buf_ioc,
    input  logic        desc_fetch,
    input  logic        xfer_req,
    input  logic        fifo_lim,
    output logic        fifo_move,
    output logic        fifo_stall,
    output logic        irq
);

    localparam int CTRL_W = $bits(ctrl_t);

    sel_e             sel;
    ctrl_t            ctrl_q;
    logic [IDX_W-1:0] lvi_q;
    logic [IDX_W-1:0] civ_q;
    logic             lvi_wr;
    flags_t           clr;
    flags_t           set;
    flags_t           flags_q;
    logic             celv_q;
    logic             halted;
    logic             running;
    logic             ev_last;
    logic [15:0]      stat;

    assign sel = sel_e'(acc_sel);

    rs_ctrl_regs #(.IDX_W(IDX_W)) i_regs (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .wr     (acc_wr),
        .word   (acc_word),
        .wdata  (acc_wdata),
        .ctrl_q (ctrl_q),
        .lvi_q  (lvi_q),
        .lvi_wr (lvi_wr),
        .clr    (clr)
    );

    rs_ring_track #(.IDX_W(IDX_W), .TX_DIR(TX_DIR)) i_ring (
        .clk        (clk),
        .rst        (rst),
        .run        (ctrl_q.run),
        .buf_done   (buf_done),
        .desc_fetch (desc_fetch),
        .lvi_wr     (lvi_wr),
        .lvi_q      (lvi_q),
        .lvi_new    (acc_wdata[IDX_W-1:0]),
        .civ_q      (civ_q),
        .celv_q     (celv_q),
        .halted     (halted),
        .running    (running),
        .ev_last    (ev_last)
    );

    // a blocked transfer drops (receive) or repeats (transmit) a sample
    assign fifo_move  = xfer_req && !fifo_lim;
    assign fifo_stall = xfer_req && fifo_lim;

    always_comb begin
        set       = '0;
        set.fifo  = fifo_stall && running;
        set.buf_c = buf_done && buf_ioc && running;
        set.lvb   = ev_last;
    end

    rs_evt_flags i_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set),
        .clr_i   (clr),
        .ctrl    (ctrl_q),
        .flags_q (flags_q),
        .irq     (irq)
    );

    assign stat = pack_stat(flags_q, celv_q, halted);

    always_comb begin
        acc_rdata = '0;
        if (acc_word) begin
            case (sel)
                SEL_STAT: acc_rdata = stat;
                SEL_CTRL: acc_rdata[CTRL_W-1:0] = ctrl_q;
                SEL_LVI:  acc_rdata[IDX_W-1:0] = lvi_q;
                SEL_CIV:  acc_rdata[IDX_W-1:0] = civ_q;
                default:  acc_rdata = '0;
            endcase
        end
    end

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags_q != '0));  // R11

    AST_NO_FIFO_ERR_HALTED: assert property (@(posedge clk) disable iff (rst)
        (halted && !flags_q.fifo) |=> !flags_q.fifo);  // R6

    AST_HALT_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.run |-> stat[0]);  // R10

endmodule

// File: tb/test_dma_ring_status.sv
`timescale 1ns/1ps
module test_dma_ring_status;

    localparam int CLK_PERIOD = 40;
    localparam int N_RAND     = 3000;
    localparam int SEED       = 20240611;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  acc_sel = '0;
    logic        acc_wr = 1'b0;
    logic        acc_word = 1'b1;
    logic [15:0] acc_wdata = '0;
    logic        buf_done = 1'b0;
    logic        buf_ioc = 1'b0;
    logic        desc_fetch = 1'b0;
    logic        xfer_req = 1'b0;
    logic        fifo_lim = 1'b0;

    logic [15:0] rd [2];
    logic        mv [2];
    logic        st [2];
    logic        iq [2];

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference state, index 0 = receive, 1 = transmit
    logic [4:0] m_civ [2];
    logic [4:0] m_lvi [2];
    logic       m_celv [2];
    logic [2:0] m_ctrl [2];
    logic [2:0] m_flg [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_ring_status #(.IDX_W(5), .TX_DIR(1'b0)) i_dma_ring_status (
        .clk(clk), .rst(rst), .acc_sel(acc_sel), .acc_wr(acc_wr), .acc_word(acc_word),
        .acc_wdata(acc_wdata), .acc_rdata(rd[0]), .buf_done(buf_done), .buf_ioc(buf_ioc),
        .desc_fetch(desc_fetch), .xfer_req(xfer_req), .fifo_lim(fifo_lim),
        .fifo_move(mv[0]), .fifo_stall(st[0]), .irq(iq[0])
    );

    dma_ring_status #(.IDX_W(5), .TX_DIR(1'b1)) i_dma_ring_status_tx (
        .clk(clk), .rst(rst), .acc_sel(acc_sel), .acc_wr(acc_wr), .acc_word(acc_word),
        .acc_wdata(acc_wdata), .acc_rdata(rd[1]), .buf_done(buf_done), .buf_ioc(buf_ioc),
        .desc_fetch(desc_fetch), .xfer_req(xfer_req), .fifo_lim(fifo_lim),
        .fifo_move(mv[1]), .fifo_stall(st[1]), .irq(iq[1])
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_halt(int d);
        return !m_ctrl[d][0] || m_celv[d];
    endfunction

    function automatic logic exp_irq(int d);
        return m_flg[d][1] || (m_flg[d][0] && m_ctrl[d][1]) || (m_flg[d][2] && m_ctrl[d][2]);
    endfunction

    task automatic model_reset();
        for (int d = 0; d < 2; d++) begin
            m_civ[d] = '0; m_lvi[d] = '0; m_celv[d] = 1'b0; m_ctrl[d] = '0; m_flg[d] = '0;
        end
    endtask

    // advance the reference by one edge using the inputs now applied
    task automatic model_step(int d);
        logic act, atl, fin, sf, sb, sl, wok;
        logic [2:0] clr;
        logic [4:0] civ_n;
        logic celv_n;
        act = m_ctrl[d][0] && !m_celv[d];
        atl = (m_civ[d] == m_lvi[d]);
        fin = buf_done && act && atl;
        sf  = xfer_req && fifo_lim && act;
        sb  = buf_done && buf_ioc && act;
        sl  = (d == 1) ? (desc_fetch && act && atl) : fin;
        wok = acc_wr && acc_word;
        clr = (wok && acc_sel == 2'd0) ? acc_wdata[4:2] : 3'b000;
        civ_n  = m_civ[d];
        celv_n = m_celv[d];
        if (wok && acc_sel == 2'd2) begin
            celv_n = 1'b0;
            if (m_celv[d] && acc_wdata[4:0] != m_civ[d]) civ_n = m_civ[d] + 5'd1;
        end else if (fin) begin
            celv_n = 1'b1;
        end
        if (buf_done && act && !atl) civ_n = m_civ[d] + 5'd1;
        m_flg[d]  = {sf, sb, sl} | (m_flg[d] & ~clr);
        m_civ[d]  = civ_n;
        m_celv[d] = celv_n;
        if (wok && acc_sel == 2'd1) m_ctrl[d] = acc_wdata[2:0];
        if (wok && acc_sel == 2'd2) m_lvi[d] = acc_wdata[4:0];
    endtask

    task automatic check_all();
        for (int s = 0; s < 4; s++) begin
            acc_sel  = 2'(s);
            acc_word = 1'b1;
            #1;
            for (int d = 0; d < 2; d++) begin
                case (s)
                    0: begin
                        chk("R10", "halted bit", int'(rd[d][0]), int'(exp_halt(d)));
                        chk("R3",  "celv bit",   int'(rd[d][1]), int'(m_celv[d]));
                        chk("R5",  "last-buffer event", int'(rd[d][2]), int'(m_flg[d][0]));
                        chk("R4",  "buffer event", int'(rd[d][3]), int'(m_flg[d][1]));
                        chk("R6",  "fifo error", int'(rd[d][4]), int'(m_flg[d][2]));
                        chk("R2",  "reserved bits", int'(rd[d][15:5]), 0);
                    end
                    1: chk("R2", "control reg", int'(rd[d]), int'(m_ctrl[d]));
                    2: chk("R9", "last valid index", int'(rd[d]), int'(m_lvi[d]));
                    default: chk("R3", "current index", int'(rd[d]), int'(m_civ[d]));
                endcase
            end
            acc_word = 1'b0;
            #1;
            for (int d = 0; d < 2; d++) chk("R2", "byte read", int'(rd[d]), 0);
        end
        acc_word = 1'b1;
        for (int d = 0; d < 2; d++) chk("R11", "irq", int'(iq[d]), int'(exp_irq(d)));
    endtask

    // inputs are set by the caller just after a falling edge
    task automatic cycle();
        #1;
        for (int d = 0; d < 2; d++) begin
            chk("R7", "fifo_move",  int'(mv[d]), int'(xfer_req && !fifo_lim));
            chk("R7", "fifo_stall", int'(st[d]), int'(xfer_req && fifo_lim));
        end
        model_step(0);
        model_step(1);
        @(posedge clk);
        #1;
        acc_wr = 1'b0; buf_done = 1'b0; buf_ioc = 1'b0; desc_fetch = 1'b0;
        xfer_req = 1'b0; fifo_lim = 1'b0;
        check_all();
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [15:0] v);
        acc_sel = s; acc_wr = 1'b1; acc_word = 1'b1; acc_wdata = v;
        cycle();
    endtask

    task automatic finish_buf(input logic ioc);
        buf_done = 1'b1; buf_ioc = ioc;
        cycle();
    endtask

    initial begin
        int r;
        r = $urandom(SEED);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        acc_sel = 2'd0; acc_word = 1'b1; #1;
        chk("R1", "status after reset", int'(rd[0]), 16'h0001);
        chk("R1", "tx status after reset", int'(rd[1]), 16'h0001);
        chk("R1", "irq after reset", int'(iq[0] || iq[1]), 0);
        check_all();
        @(negedge clk);

        // byte write to control must be ignored (R2)
        acc_sel = 2'd1; acc_wr = 1'b1; acc_word = 1'b0; acc_wdata = 16'h0007;
        cycle();
        chk("R2", "byte write ignored", int'(rd[0][0]), 0);

        // walk three buffers to the last valid index
        wr_reg(2'd2, 16'd3);
        wr_reg(2'd1, 16'h0007);
        finish_buf(1'b1);
        finish_buf(1'b0);
        finish_buf(1'b0);
        desc_fetch = 1'b1;
        cycle();
        finish_buf(1'b0);
        acc_sel = 2'd0; #1;
        chk("R3", "halt at last valid", int'(rd[0][1:0]), 3);
        chk("R5", "rx last event", int'(rd[0][2]), 1);
        finish_buf(1'b1);
        acc_sel = 2'd3; #1;
        chk("R3", "ignored after halt", int'(rd[0]), 3);
        @(negedge clk);

        // new last valid index resumes, then clear and set in one cycle (R8)
        wr_reg(2'd2, 16'd5);
        acc_sel = 2'd3; #1;
        chk("R9", "advance on new index", int'(rd[0]), 4);
        @(negedge clk);
        acc_sel = 2'd0; acc_wr = 1'b1; acc_word = 1'b1; acc_wdata = 16'h001F;
        buf_done = 1'b1; buf_ioc = 1'b1;
        cycle();
        acc_sel = 2'd0; #1;
        chk("R8", "set wins over clear", int'(rd[0][3]), 1);
        chk("R8", "clear takes effect", int'(rd[0][2]), 0);
        @(negedge clk);

        // wrap from 31 to 0
        wr_reg(2'd2, 16'd31);
        while (m_civ[0] != 5'd31 || !m_celv[0]) finish_buf(1'b0);
        wr_reg(2'd2, 16'd1);
        acc_sel = 2'd3; #1;
        chk("R3", "index wraps", int'(rd[0]), 0);
        @(negedge clk);

        // FIFO error while running and while halted
        xfer_req = 1'b1; fifo_lim = 1'b1;
        cycle();
        acc_sel = 2'd0; #1;
        chk("R6", "fifo error while running", int'(rd[0][4]), 1);
        @(negedge clk);
        wr_reg(2'd0, 16'h0010);
        wr_reg(2'd1, 16'h0000);
        xfer_req = 1'b1; fifo_lim = 1'b1;
        cycle();
        acc_sel = 2'd0; #1;
        chk("R6", "no fifo error while halted", int'(rd[0][4]), 0);
        @(negedge clk);
        wr_reg(2'd1, 16'h0007);

        for (int n = 0; n < N_RAND; n++) begin
            buf_done   = ($urandom % 100) < 30;
            buf_ioc    = $urandom % 2;
            desc_fetch = ($urandom % 100) < 20;
            xfer_req   = ($urandom % 100) < 30;
            fifo_lim   = ($urandom % 100) < 30;
            if (($urandom % 100) < 12) begin
                acc_wr   = 1'b1;
                acc_sel  = 2'($urandom % 4);
                acc_word = ($urandom % 8) != 0;
                case (acc_sel)
                    2'd1:    acc_wdata = {13'd0, 2'($urandom % 4), 1'(($urandom % 5) != 0)};
                    2'd2:    acc_wdata = {11'd0, 5'(m_civ[0] + 5'($urandom % 4))};
                    default: acc_wdata = 16'($urandom);
                endcase
            end
            cycle();
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule